// File: doc/BRIEF.md
# Two-Master AUX Channel Ownership Arbiter

This block decides who may drive a single DisplayPort AUX channel: a software register port or an embedded display microcontroller. Each master has a request pulse and a release pulse. A two-bit ownership field tells both sides who holds the channel. Software learns whether its request succeeded by reading that field after it asks. Software gives up the channel with a separate done pulse. Dropping or repeating its request pulse does not release it.

When software asks for a channel that is switched off, the block does not grant it at once. First it switches the channel on and raises the channel reset in the same cycle. It then waits for the channel's reset-done acknowledge to rise. Next it lowers the reset and waits for reset-done to fall again. Only then is software granted. If the microcontroller asks while software holds the channel or the sequence is running, the request is held pending and granted once the channel is free. If software asks while the microcontroller owns the channel, the request is refused and is not remembered.

The controller has five named states. `IDLE` means nobody owns the channel. `EN_RST` holds enable and reset high and waits for reset-done. `RST_REL` holds reset low and waits for reset-done to clear. `SW_OWN` and `MC_OWN` mean software or the microcontroller owns the channel. The transitions are:
- `IDLE->MC_OWN` on a microcontroller request, whether new or pending.
- `IDLE->SW_OWN` on a software request while the channel is enabled.
- `IDLE->EN_RST` on a software request while the channel is disabled.
- `EN_RST->RST_REL` when reset-done is seen high.
- `RST_REL->SW_OWN` when reset-done is seen low.
- `SW_OWN->IDLE` on the done pulse.
- `MC_OWN->IDLE` on the microcontroller release.

Top module: `aux_chan_arbiter`

## Requirements
- R1: The ownership field `own_stat` is 0 when nobody owns the channel, 1 when software owns it and 2 when the microcontroller owns it. It never reads 3. It reads 0 after reset, and `chan_en` and `chan_rst` read 0 after reset.
- R2: A software request in the idle state with `chan_en`=1 sets `own_stat` to 1 on the next clock edge.
- R3: A software request while `own_stat`=2 is refused. `own_stat` stays 2, and the request is not remembered: after the microcontroller releases, `own_stat` reads 0 and stays 0.
- R4: A software request in the idle state with `chan_en`=0 raises `chan_en` and `chan_rst` together on the next edge. `own_stat` stays 0 while the sequence runs.
- R5: `chan_rst` falls on the edge after `rst_done` is sampled high. Software is granted (`own_stat`=1) on the edge after `rst_done` is then sampled low.
- R6: Software releases only through `sw_done`. Further `sw_req` pulses while it owns the channel keep `own_stat` at 1. After `sw_done`, `own_stat` reads 0 on the next edge.
- R7: When both masters request in the same idle cycle, the microcontroller wins: `own_stat` becomes 2.
- R8: A microcontroller request made while software owns the channel, or while the sequence runs, is held pending. `own_stat` reads 0 for one cycle after the release and then reads 2.
- R9: `mc_rel` while the microcontroller owns the channel sets `own_stat` to 0 on the next edge. `sw_done` has no effect in that state.
- R10: A write on `en_wr` loads `en_val` into `chan_en` on the next edge, except while the enable-and-reset sequence runs, when the write is ignored and `chan_en` stays 1.
- R11: `chan_rst` is 1 only during the sequence, and `chan_rst`=1 always comes with `chan_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Software request pulse |
| sw_done | input | 1 | Software done-using pulse (release) |
| mc_req | input | 1 | Microcontroller request pulse |
| mc_rel | input | 1 | Microcontroller release pulse |
| en_wr | input | 1 | Enable-bit write strobe |
| en_val | input | 1 | Value written to the enable bit |
| rst_done | input | 1 | Reset-done acknowledge from the channel |
| chan_en | output | 1 | Channel enable |
| chan_rst | output | 1 | Channel reset |
| own_stat | output | 2 | Ownership field: 0 none, 1 software, 2 microcontroller |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it, because the state register drives the ownership field and the reset output. A pending microcontroller request takes two edges after the release: one to reach idle and one to grant. During the enable sequence the channel model in the bench raises reset-done four edges after reset rises and lowers it four edges after reset falls. Software is therefore granted on the tenth edge after its request. Inputs are driven on the falling edge and outputs are sampled on the following falling edge. The bench then checks the expected value for each edge of the sequence, one edge at a time.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;
    localparam int STAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_EN_RST  = 3'd1,
        ST_RST_REL = 3'd2,
        ST_SW_OWN  = 3'd3,
        ST_MC_OWN  = 3'd4
    } arb_state_t;

    localparam logic [STAT_W-1:0] OWN_NONE = 2'd0;
    localparam logic [STAT_W-1:0] OWN_SW   = 2'd1;
    localparam logic [STAT_W-1:0] OWN_MC   = 2'd2;
endpackage

// File: rtl/aux_mc_pend.sv
// Holds a microcontroller request that arrived while the channel was busy.
module aux_mc_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_req,
    input  logic mc_grant,
    output logic mc_want
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mc_grant) begin
            pend_q <= 1'b0;
        end else if (mc_req) begin
            pend_q <= 1'b1;
        end
    end

    assign mc_want = mc_req | pend_q;
endmodule

// File: rtl/aux_en_reg.sv
// Channel enable bit: set by the sequence start, written by software otherwise.
module aux_en_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic seq_start,
    input  logic seq_busy,
    output logic chan_en
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (seq_start) begin
            en_q <= 1'b1;
        end else if (en_wr && !seq_busy) begin
            en_q <= en_val;
        end
    end

    assign chan_en = en_q;
endmodule

// File: rtl/aux_own_fsm.sv
// Ownership state machine with the enable-and-reset handshake.
module aux_own_fsm
    import aux_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              sw_done,
    input  logic              mc_want,
    input  logic              mc_rel,
    input  logic              chan_en,
    input  logic              rst_done,
    output logic [STAT_W-1:0] own_stat,
    output logic              chan_rst,
    output logic              seq_busy,
    output logic              seq_start,
    output logic              mc_grant
);
    arb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        seq_start = 1'b0;
        mc_grant  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mc_want) begin
                    state_d  = ST_MC_OWN;
                    mc_grant = 1'b1;
                end else if (sw_req) begin
                    if (chan_en) begin
                        state_d = ST_SW_OWN;
                    end else begin
                        state_d   = ST_EN_RST;
                        seq_start = 1'b1;
                    end
                end
            end
            ST_EN_RST: begin
                if (rst_done) state_d = ST_RST_REL;
            end
            ST_RST_REL: begin
                if (!rst_done) state_d = ST_SW_OWN;
            end
            ST_SW_OWN: begin
                if (sw_done) state_d = ST_IDLE;
            end
            ST_MC_OWN: begin
                if (mc_rel) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        own_stat = OWN_NONE;
        chan_rst = 1'b0;
        seq_busy = 1'b0;
        unique case (state_q)
            ST_IDLE:    own_stat = OWN_NONE;
            ST_EN_RST:  begin chan_rst = 1'b1; seq_busy = 1'b1; end
            ST_RST_REL: seq_busy = 1'b1;
            ST_SW_OWN:  own_stat = OWN_SW;
            ST_MC_OWN:  own_stat = OWN_MC;
            default:    own_stat = OWN_NONE;
        endcase
    end
endmodule

// File: rtl/aux_chan_arbiter.sv
module aux_chan_arbiter
    import aux_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              sw_done,
    input  logic              mc_req,
    input  logic              mc_rel,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              rst_done,
    output logic              chan_en,
    output logic              chan_rst,
    output logic [STAT_W-1:0] own_stat
);
    logic mc_want;
    logic mc_grant;
    logic seq_start;
    logic seq_busy;

    aux_mc_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_req   (mc_req),
        .mc_grant (mc_grant),
        .mc_want  (mc_want)
    );

    aux_en_reg u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .seq_start (seq_start),
        .seq_busy  (seq_busy),
        .chan_en   (chan_en)
    );

    aux_own_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .sw_done   (sw_done),
        .mc_want   (mc_want),
        .mc_rel    (mc_rel),
        .chan_en   (chan_en),
        .rst_done  (rst_done),
        .own_stat  (own_stat),
        .chan_rst  (chan_rst),
        .seq_busy  (seq_busy),
        .seq_start (seq_start),
        .mc_grant  (mc_grant)
    );
endmodule

// File: rtl/aux_arb_chk.sv
module aux_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_done,
    input logic       mc_req,
    input logic       mc_rel,
    input logic       rst_done,
    input logic       chan_en,
    input logic       chan_rst,
    input logic       seq_busy,
    input logic [1:0] own_stat
);
    assert_stat_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        own_stat != 2'd3);

    assert_mc_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_stat == 2'd2 && !mc_rel) |=> own_stat == 2'd2);

    assert_rst_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst && rst_done) |=> !chan_rst);

    assert_sw_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_stat == 2'd1 && !sw_done) |=> own_stat == 2'd1);

    assert_mc_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (own_stat == 2'd0 && !seq_busy && mc_req) |=> own_stat == 2'd2);

    assert_mc_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (own_stat == 2'd2 && mc_rel) |=> own_stat == 2'd0);

    assert_rst_with_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |-> chan_en);

    assert_rst_no_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |-> own_stat == 2'd0);
endmodule

bind aux_chan_arbiter aux_arb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_done  (sw_done),
    .mc_req   (mc_req),
    .mc_rel   (mc_rel),
    .rst_done (rst_done),
    .chan_en  (chan_en),
    .chan_rst (chan_rst),
    .seq_busy (seq_busy),
    .own_stat (own_stat)
);

// File: tb/test_aux_chan_arbiter.sv
`timescale 1ns/1ps
module test_aux_chan_arbiter;
    localparam int ACK_DLY = 4;
    localparam int NVEC    = 14;

    // inputs {sw_req, sw_done, mc_req, mc_rel, en_wr, en_val}, expected stat, en, req tag
    typedef struct packed {
        logic [5:0] in;
        logic [1:0] stat;
        logic       en;
        logic [3:0] tag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{6'b000011, 2'd0, 1'b1, 4'd10}, // R10 enable write
        '{6'b100000, 2'd1, 1'b1, 4'd2},  // R2 grant
        '{6'b000000, 2'd1, 1'b1, 4'd6},  // R6 held
        '{6'b100000, 2'd1, 1'b1, 4'd6},  // R6 repeat request
        '{6'b001000, 2'd1, 1'b1, 4'd8},  // R8 mc pends
        '{6'b010000, 2'd0, 1'b1, 4'd6},  // R6 release
        '{6'b000000, 2'd2, 1'b1, 4'd8},  // R8 pending grant
        '{6'b100000, 2'd2, 1'b1, 4'd3},  // R3 refused
        '{6'b010000, 2'd2, 1'b1, 4'd9},  // R9 sw_done no effect
        '{6'b000100, 2'd0, 1'b1, 4'd9},  // R9 release
        '{6'b000000, 2'd0, 1'b1, 4'd3},  // R3 not remembered
        '{6'b101000, 2'd2, 1'b1, 4'd7},  // R7 tie
        '{6'b000100, 2'd0, 1'b1, 4'd9},  // R9 release
        '{6'b000010, 2'd0, 1'b0, 4'd10}  // R10 disable
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req = 0, sw_done = 0, mc_req = 0, mc_rel = 0, en_wr = 0, en_val = 0;
    logic rst_done;
    logic chan_en, chan_rst;
    logic [1:0] own_stat;
    logic [ACK_DLY-1:0] dl;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // channel model: reset-done follows reset after ACK_DLY edges
    always_ff @(posedge clk) begin
        if (!rst_n) dl <= '0;
        else        dl <= {dl[ACK_DLY-2:0], chan_rst};
    end
    assign rst_done = dl[ACK_DLY-1];

    aux_chan_arbiter i_aux_chan_arbiter (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_done(sw_done),
        .mc_req(mc_req), .mc_rel(mc_rel), .en_wr(en_wr), .en_val(en_val),
        .rst_done(rst_done), .chan_en(chan_en), .chan_rst(chan_rst),
        .own_stat(own_stat)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {sw_req, sw_done, mc_req, mc_rel, en_wr, en_val} = v;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 stat", int'(own_stat), 0);
        chk("R1 en", int'(chan_en), 0);
        chk("R1 rst", int'(chan_rst), 0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].in);
            step();
            chk($sformatf("R%0d stat v%0d", VECS[i].tag, i), int'(own_stat), int'(VECS[i].stat));
            chk($sformatf("R%0d en v%0d", VECS[i].tag, i), int'(chan_en), int'(VECS[i].en));
            chk($sformatf("R11 rst v%0d", i), int'(chan_rst), 0);
        end
        drive(6'b0);

        // R4 and R5: enable-and-reset sequence from a disabled channel
        sw_req = 1'b1;
        step();
        sw_req = 1'b0;
        chk("R4 en", int'(chan_en), 1);
        chk("R4 rst", int'(chan_rst), 1);
        chk("R4 stat", int'(own_stat), 0);
        en_wr = 1'b1; en_val = 1'b0; mc_req = 1'b1;   // R10 ignored, R8 pends
        for (int i = 1; i <= 2*ACK_DLY + 2; i++) begin
            step();
            en_wr = 1'b0; mc_req = 1'b0;
            chk($sformatf("R5 rst e%0d", i), int'(chan_rst), (i <= ACK_DLY) ? 1 : 0);
            chk($sformatf("R5 stat e%0d", i), int'(own_stat), (i >= 2*ACK_DLY + 2) ? 1 : 0);
            chk($sformatf("R10 en e%0d", i), int'(chan_en), 1);
        end
        // R8: pending microcontroller request after software release
        sw_done = 1'b1;
        step();
        sw_done = 1'b0;
        chk("R8 idle gap", int'(own_stat), 0);
        step();
        chk("R8 granted", int'(own_stat), 2);
        mc_rel = 1'b1;
        step();
        mc_rel = 1'b0;
        chk("R9 release", int'(own_stat), 0);

        // R1: reset mid-ownership returns to zero
        mc_req = 1'b1;
        step();
        mc_req = 1'b0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R1 reset stat", int'(own_stat), 0);
        chk("R1 reset en", int'(chan_en), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule